// File: doc/BRIEF.md
# Driver Fault and Inhibit Supervisor

This block is the global protection controller for a twelve-channel load driver. It receives the supply undervoltage comparator, the thermal prewarning and thermal shutdown comparator flags (hysteresis is applied before they arrive), the hardware inhibit pin, the software run bit, a delay-select bit, a one-cycle status-clear pulse and a slow timebase tick. From these it produces one global output-disable, three status bits (supply fail, temperature prewarning, standby) and a force signal that makes every bit of the downstream status word read as 1.

Each fault class recovers in its own way. Undervoltage must persist for a selectable number of ticks before it trips. Once the supply is good again the outputs come back at once, but the supply-fail flag stays set. Thermal shutdown latches and is released only by a clear command given while the die is cool. Standby is the OR of the pin and the register bit, and it follows them without latching. All outputs are registered. Each output changes on the first clock edge after the input that causes it.

Top module: `drv_fault_supervisor`

## Requirements
- R1: While reset is held, `out_dis_o`=1, `inh_o`=1, and `psf_o`, `tp_o` and `tsd_force_o` are 0.
- R2: With `uv_i` held at 1, the supervisor trips on the clock edge that samples the N-th `tick_i` pulse, where N is `UV_SHORT_TICKS` when `long_dly_i`=0 and `UV_LONG_TICKS` when `long_dly_i`=1. From the next cycle, `psf_o`=1 and `out_dis_o`=1. Cycles without a tick do not advance the count.
- R3: If `uv_i` falls before N ticks, the count returns to zero and `psf_o` stays 0. A later undervoltage needs a full N ticks again.
- R4: One cycle after `uv_i` falls, the outputs are no longer disabled for undervoltage. `psf_o` stays at 1 until it is cleared.
- R5: A `stat_clr_i` pulse clears `psf_o` on the next cycle only if the undervoltage trip is no longer present. While the trip persists, the clear has no effect.
- R6: When thermal shutdown is not active, `tp_o` equals `tpw_i` delayed by one cycle, and it is never latched.
- R7: One cycle after `tsd_i`=1, `tsd_force_o`=1. While it is 1, `out_dis_o`, `psf_o`, `tp_o` and `inh_o` all read 1.
- R8: `tsd_force_o` falls only on the cycle after `stat_clr_i`=1 while `tsd_i`=0. Cooling without a clear does not release it, and neither does a clear while hot.
- R9: One cycle after (`inh_pin_i`=0 or `sw_run_i`=0), `inh_o`=1 and `out_dis_o`=1. When both are 1, standby ends one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase tick, one cycle wide |
| uv_i | input | 1 | Supply undervoltage comparator, 1 = low supply |
| tpw_i | input | 1 | Thermal prewarning comparator, 1 = warm |
| tsd_i | input | 1 | Thermal shutdown comparator, 1 = above switch-off threshold |
| inh_pin_i | input | 1 | Hardware inhibit pin, 0 = standby |
| sw_run_i | input | 1 | Software run bit, 0 = standby |
| long_dly_i | input | 1 | Delay select, 1 = long undervoltage delay |
| stat_clr_i | input | 1 | Status clear pulse |
| out_dis_o | output | 1 | Global disable of all output stages |
| psf_o | output | 1 | Supply-fail status bit |
| tp_o | output | 1 | Temperature prewarning status bit |
| inh_o | output | 1 | Standby status bit |
| tsd_force_o | output | 1 | Thermal shutdown; forces every status bit to 1 |

## Verification
The bench builds the block with `UV_SHORT_TICKS`=3 and `UV_LONG_TICKS`=6. With these values it can sweep every undervoltage pulse length from one tick to one tick past the limit, for both delay settings. This covers the exact trip boundary on both sides, and the recovery and clear behaviour after each trip. The small limits also allow the bench to run all four inhibit input combinations and the full set of thermal latch, cool and clear orderings.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

  localparam int unsigned STAT_BITS = 3;

  typedef enum logic [1:0] {
    STAT_PSF = 2'd0,
    STAT_TP  = 2'd1,
    STAT_INH = 2'd2
  } fsup_stat_idx_e;

  typedef logic [STAT_BITS-1:0] fsup_stat_t;

endpackage

// File: rtl/fsup_rst_sync.sv
module fsup_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/fsup_uv_timer.sv
module fsup_uv_timer #(
  parameter int unsigned SHORT_TICKS = 12,
  parameter int unsigned LONG_TICKS  = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic uv_i,
  input  logic long_sel_i,
  input  logic clr_i,
  output logic trip_o,
  output logic psf_o
);

  localparam int unsigned MAX_TICKS = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int unsigned CW        = $clog2(MAX_TICKS + 1);
  localparam logic [CW-1:0] LIM_S   = CW'(SHORT_TICKS - 1);
  localparam logic [CW-1:0] LIM_L   = CW'(LONG_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          trip_q, trip_d;
  logic          psf_q, psf_d;
  logic [CW-1:0] lim;
  logic          cnt_en;

  assign lim = long_sel_i ? LIM_L : LIM_S;

  // counter only moves on a tick during undervoltage, or to clear on recovery
  assign cnt_en = !uv_i || (tick_i && !trip_q);

  always_comb begin
    cnt_d  = cnt_q;
    trip_d = trip_q;
    if (!uv_i) begin
      cnt_d  = '0;
      trip_d = 1'b0;
    end else if (tick_i && !trip_q) begin
      if (cnt_q >= lim) begin
        trip_d = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    // an active trip wins over a clear request
    psf_d = trip_d || (psf_q && !clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip_q <= 1'b0;
      psf_q  <= 1'b0;
    end else begin
      trip_q <= trip_d;
      psf_q  <= psf_d;
    end
  end

  assign trip_o = trip_q;
  assign psf_o  = psf_q;

endmodule

// File: rtl/fsup_thermal.sv
module fsup_thermal (
  input  logic clk,
  input  logic rst_n,
  input  logic tpw_i,
  input  logic tsd_i,
  input  logic clr_i,
  output logic tp_o,
  output logic tsd_o
);

  logic tp_q, tp_d;
  logic tsd_q, tsd_d;

  always_comb begin
    tp_d  = tpw_i;
    // shutdown is held while hot; release needs a clear after cooling
    tsd_d = tsd_i || (tsd_q && !clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tp_q  <= 1'b0;
      tsd_q <= 1'b0;
    end else begin
      tp_q  <= tp_d;
      tsd_q <= tsd_d;
    end
  end

  assign tp_o  = tp_q;
  assign tsd_o = tsd_q;

endmodule

// File: rtl/fsup_inhibit.sv
module fsup_inhibit (
  input  logic clk,
  input  logic rst_n,
  input  logic inh_pin_i,
  input  logic sw_run_i,
  output logic inh_o
);

  logic inh_q, inh_d;

  always_comb begin
    inh_d = !inh_pin_i || !sw_run_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inh_q <= 1'b1;
    end else begin
      inh_q <= inh_d;
    end
  end

  assign inh_o = inh_q;

endmodule

// File: rtl/drv_fault_supervisor.sv
module drv_fault_supervisor
  import fsup_pkg::*;
#(
  parameter int unsigned UV_SHORT_TICKS = 12,
  parameter int unsigned UV_LONG_TICKS  = 96,
  parameter int unsigned RST_STAGES     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic uv_i,
  input  logic tpw_i,
  input  logic tsd_i,
  input  logic inh_pin_i,
  input  logic sw_run_i,
  input  logic long_dly_i,
  input  logic stat_clr_i,
  output logic out_dis_o,
  output logic psf_o,
  output logic tp_o,
  output logic inh_o,
  output logic tsd_force_o
);

  logic       rst_q_n;
  logic       uv_trip;
  logic       tsd_lat;
  fsup_stat_t raw_stat;
  fsup_stat_t out_stat;

  fsup_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  fsup_uv_timer #(
    .SHORT_TICKS (UV_SHORT_TICKS),
    .LONG_TICKS  (UV_LONG_TICKS)
  ) u_uv_timer (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .tick_i     (tick_i),
    .uv_i       (uv_i),
    .long_sel_i (long_dly_i),
    .clr_i      (stat_clr_i),
    .trip_o     (uv_trip),
    .psf_o      (raw_stat[STAT_PSF])
  );

  fsup_thermal u_thermal (
    .clk   (clk),
    .rst_n (rst_q_n),
    .tpw_i (tpw_i),
    .tsd_i (tsd_i),
    .clr_i (stat_clr_i),
    .tp_o  (raw_stat[STAT_TP]),
    .tsd_o (tsd_lat)
  );

  fsup_inhibit u_inhibit (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .inh_pin_i (inh_pin_i),
    .sw_run_i  (sw_run_i),
    .inh_o     (raw_stat[STAT_INH])
  );

  // thermal shutdown overrides every status bit
  for (genvar g = 0; g < STAT_BITS; g++) begin : g_force
    assign out_stat[g] = raw_stat[g] || tsd_lat;
  end

  assign out_dis_o   = uv_trip || tsd_lat || raw_stat[STAT_INH];
  assign psf_o       = out_stat[STAT_PSF];
  assign tp_o        = out_stat[STAT_TP];
  assign inh_o       = out_stat[STAT_INH];
  assign tsd_force_o = tsd_lat;

endmodule

// File: rtl/fsup_checker.sv
module fsup_checker (
  input logic clk,
  input logic rst_n,
  input logic uv_i,
  input logic tpw_i,
  input logic tsd_i,
  input logic inh_pin_i,
  input logic sw_run_i,
  input logic stat_clr_i,
  input logic out_dis_o,
  input logic psf_o,
  input logic tp_o,
  input logic inh_o,
  input logic tsd_force_o
);

  // R3: supply-fail cannot appear without undervoltage present
  p_psf_needs_uv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(psf_o) && !tsd_force_o) |-> $past(uv_i));

  // R4: recovery is immediate when nothing else holds the outputs off
  p_uv_recover_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!uv_i && inh_pin_i && sw_run_i && !tsd_i && !tsd_force_o) |=> !out_dis_o);

  // R5: supply-fail stays set without a clear
  p_psf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (psf_o && !stat_clr_i) |=> psf_o);

  // R6: prewarning follows its comparator one cycle later
  p_tp_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tsd_i && !tsd_force_o) |=> (tp_o == $past(tpw_i)));

  // R7: hot comparator forces shutdown on the next cycle
  p_tsd_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tsd_i |=> tsd_force_o);

  // R7: all status bits and the disable read 1 during shutdown
  p_force_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tsd_force_o |-> (out_dis_o && psf_o && tp_o && inh_o));

  // R8: shutdown persists until a clear is given
  p_tsd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tsd_force_o && !stat_clr_i) |=> tsd_force_o);

  // R9: either inhibit source disables the outputs
  p_inhibit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!inh_pin_i || !sw_run_i) |=> (inh_o && out_dis_o));

endmodule

bind drv_fault_supervisor fsup_checker u_fsup_checker (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .uv_i        (uv_i),
  .tpw_i       (tpw_i),
  .tsd_i       (tsd_i),
  .inh_pin_i   (inh_pin_i),
  .sw_run_i    (sw_run_i),
  .stat_clr_i  (stat_clr_i),
  .out_dis_o   (out_dis_o),
  .psf_o       (psf_o),
  .tp_o        (tp_o),
  .inh_o       (inh_o),
  .tsd_force_o (tsd_force_o)
);

// File: tb/test_drv_fault_supervisor.sv
module test_drv_fault_supervisor;

  localparam int unsigned SHORT_T = 3;
  localparam int unsigned LONG_T  = 6;

  logic clk;
  logic rst_n;
  logic tick_i, uv_i, tpw_i, tsd_i, inh_pin_i, sw_run_i, long_dly_i, stat_clr_i;
  logic out_dis_o, psf_o, tp_o, inh_o, tsd_force_o;

  int n_chk;
  int n_fail;

  drv_fault_supervisor #(
    .UV_SHORT_TICKS (SHORT_T),
    .UV_LONG_TICKS  (LONG_T)
  ) i_drv_fault_supervisor (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .uv_i        (uv_i),
    .tpw_i       (tpw_i),
    .tsd_i       (tsd_i),
    .inh_pin_i   (inh_pin_i),
    .sw_run_i    (sw_run_i),
    .long_dly_i  (long_dly_i),
    .stat_clr_i  (stat_clr_i),
    .out_dis_o   (out_dis_o),
    .psf_o       (psf_o),
    .tp_o        (tp_o),
    .inh_o       (inh_o),
    .tsd_force_o (tsd_force_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_pulse();
    stat_clr_i = 1'b1;
    cyc();
    stat_clr_i = 1'b0;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b0;
    tick_i = 1'b0; uv_i = 1'b0; tpw_i = 1'b0; tsd_i = 1'b0;
    inh_pin_i = 1'b1; sw_run_i = 1'b1; long_dly_i = 1'b0; stat_clr_i = 1'b0;
    repeat (3) cyc();
    // R1 reset values
    chk("R1 out_dis", out_dis_o, 1'b1);
    chk("R1 inh", inh_o, 1'b1);
    chk("R1 psf", psf_o, 1'b0);
    chk("R1 tp", tp_o, 1'b0);
    chk("R1 force", tsd_force_o, 1'b0);
    rst_n = 1'b1;
    repeat (4) cyc();
    chk("R9 standby released", inh_o, 1'b0);
    chk("R9 outputs enabled", out_dis_o, 1'b0);

    // R2 and R3: sweep pulse length across both delay settings
    for (int sel = 0; sel < 2; sel++) begin
      for (int n = 1; n <= ((sel == 1) ? LONG_T : SHORT_T) + 1; n++) begin
        automatic int  lim = (sel == 1) ? LONG_T : SHORT_T;
        automatic logic exp = (n >= lim);
        long_dly_i = sel[0];
        uv_i = 1'b1;
        for (int k = 0; k < n; k++) begin
          tick_i = 1'b1;
          cyc();
          tick_i = 1'b0;
          cyc();
        end
        chk(exp ? "R2 psf after limit" : "R3 no psf before limit", psf_o, exp);
        chk(exp ? "R2 disable after limit" : "R3 no disable before limit", out_dis_o, exp);
        uv_i = 1'b0;
        cyc();
        chk("R4 immediate enable", out_dis_o, 1'b0);
        chk("R4 psf latched", psf_o, exp);
        clear_pulse();
        chk("R5 psf cleared", psf_o, 1'b0);
      end
    end

    // R2: cycles without a tick never trip
    long_dly_i = 1'b0;
    uv_i = 1'b1;
    repeat (20) cyc();
    chk("R2 no tick no trip", psf_o, 1'b0);
    uv_i = 1'b0;
    cyc();

    // R5: clear ignored while trip persists
    uv_i = 1'b1;
    for (int k = 0; k < SHORT_T; k++) begin
      tick_i = 1'b1; cyc(); tick_i = 1'b0; cyc();
    end
    clear_pulse();
    chk("R5 clear ignored while tripped", psf_o, 1'b1);
    chk("R5 still disabled", out_dis_o, 1'b1);
    uv_i = 1'b0;
    cyc();
    clear_pulse();
    chk("R5 cleared after recovery", psf_o, 1'b0);

    // R6: prewarning follows without latching
    for (int v = 0; v < 4; v++) begin
      tpw_i = v[0];
      cyc();
      chk("R6 tp follows", tp_o, v[0]);
    end
    tpw_i = 1'b0;
    cyc();

    // R7 and R8: thermal latch, cool, clear orderings
    tsd_i = 1'b1;
    cyc();
    chk("R7 force set", tsd_force_o, 1'b1);
    chk("R7 disable", out_dis_o, 1'b1);
    chk("R7 psf forced", psf_o, 1'b1);
    chk("R7 tp forced", tp_o, 1'b1);
    chk("R7 inh forced", inh_o, 1'b1);
    clear_pulse();
    chk("R8 clear while hot ignored", tsd_force_o, 1'b1);
    tsd_i = 1'b0;
    repeat (5) cyc();
    chk("R8 cooling alone keeps latch", tsd_force_o, 1'b1);
    clear_pulse();
    chk("R8 released by clear when cool", tsd_force_o, 1'b0);
    chk("R8 outputs enabled", out_dis_o, 1'b0);
    chk("R8 psf not stuck", psf_o, 1'b0);

    // R9: all inhibit input combinations
    for (int c = 0; c < 4; c++) begin
      automatic logic exp_inh = !(c[0] && c[1]);
      inh_pin_i = c[0];
      sw_run_i  = c[1];
      cyc();
      chk("R9 inh status", inh_o, exp_inh);
      chk("R9 disable", out_dis_o, exp_inh);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule